// File: doc/BRIEF.md
# PCIe Controller Reset and Clock Bring-Up Sequencer

This block takes a PCIe controller and its PHY from whatever state earlier boot code left them in to a clean state with reset released. When a bring-up command arrives, it first checks whether the link is still running. This is the case when both the reference clock and the link training state machine (LTSSM) report enabled. If the link is running, the block forces the link state back to detect and only then turns training off. It then powers the PHY down and stops the reference clock. Next it brings up three clock gates in a fixed order, each waiting for an acknowledge. It powers the PHY back up and restarts the reference clock after a settle delay. Last, it pulses the active-low endpoint reset.

A shutdown command runs only the power-down half, so the link is left down before a reboot. All delays are counted in clock cycles against parameters. If a clock gate never acknowledges, the gates already opened are closed again, newest first, and an error is flagged. Until the first command is accepted, the block adopts the boot-time state: its LTSSM enable, reference clock enable and link-state field follow the status inputs.

Top module: `pcie_rst_seq`

## Requirements
- R1: Until the first command is accepted, ltssm_en_o, refclk_en_o and link_state_o follow ltssm_on_i, refclk_on_i and link_state_i. In that period phy_pd_o, force_link_o, clk_en_o, ep_rst_n_o, done_o and err_o are all 0.
- R2: If refclk_on_i and ltssm_on_i are both 1 when a command is accepted, force_link_o rises with link_state_o all-zero (zero is the detect state) before ltssm_en_o falls. Otherwise force_link_o is driven to 0.
- R3: The power-down half first raises phy_pd_o and then, in a later cycle, lowers refclk_en_o. Both happen after the LTSSM step of R2.
- R4: The clock gates clk_en_o[0], [1] and [2] open in that index order. Gate k+1 opens only after gate k's acknowledge (clk_ack_i[k]) has been seen.
- R5: phy_pd_o falls only after all acknowledges. refclk_en_o then rises at least PD_WAIT cycles later, and never while phy_pd_o is 1.
- R6: ep_rst_n_o falls at least SETTLE_WAIT cycles after refclk_en_o rises. It stays low at least EPRST_WAIT cycles and rises only with the reference clock on, the PHY powered and all gates open.
- R7: shutdown_i runs only the power-down half. It leaves phy_pd_o at 1 and refclk_en_o at 0, and does not change clk_en_o or ep_rst_n_o.
- R8: If gate k is not acknowledged within ACK_WAIT+1 cycles, gates k down to 0 close one per cycle in descending order. The reference clock stays off, the endpoint reset is not released, and err_o is set.
- R9: done_o is a one-cycle pulse at the end of every sequence (success, shutdown or failure). err_o rises only with done_o and is cleared when the next command is accepted.
- R10: start_i and shutdown_i are ignored while a sequence is running. If both arrive in the same cycle, start_i wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Bring-up command (power-down half, then power-up half) |
| shutdown_i | input | 1 | Shutdown command (power-down half only) |
| refclk_on_i | input | 1 | Status: reference clock currently enabled |
| ltssm_on_i | input | 1 | Status: link training currently enabled |
| link_state_i | input | LSW | Current link-state field, adopted before the first command |
| clk_ack_i | input | NCLK | Per-gate clock enable acknowledge |
| ltssm_en_o | output | 1 | Link training enable |
| phy_pd_o | output | 1 | PHY test power-down |
| refclk_en_o | output | 1 | Reference clock enable |
| force_link_o | output | 1 | Force-link request |
| link_state_o | output | LSW | Link-state field written with the force-link request |
| clk_en_o | output | NCLK | Clock gate enables (index 0 = PHY, 1 = bus, 2 = core) |
| ep_rst_n_o | output | 1 | Active-low endpoint reset |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| err_o | output | 1 | Clock acknowledge failure flag |

## Verification
The assertions check, on every cycle, the orderings that can be judged from one edge:
- the reference clock never starts while the PHY is powered down;
- a forced link always carries the detect value;
- no gate opens ahead of its predecessor;
- the endpoint reset is released only after a full low window and with everything up;
- done is a single pulse, and a failure leaves every gate closed.

Only the bench scenarios can show the rest:
- the adopt-then-own behaviour;
- the whole order of the LTSSM, power-down and clock-stop steps;
- the lengths of the settle delays;
- the descending close-down after a missing acknowledge;
- that shutdown leaves the gates and endpoint reset alone;
- that commands are ignored while a sequence runs.

// File: rtl/pcie_rs_pkg.sv
package pcie_rs_pkg;
  typedef enum logic [3:0] {
    S_IDLE,
    S_FORCE,
    S_LTOFF,
    S_PDON,
    S_REFOFF,
    S_CLKEN,
    S_UNWIND,
    S_PWRUP,
    S_REFON,
    S_EPRST,
    S_FIN
  } seq_state_e;
endpackage

// File: rtl/pcie_rs_timer.sv
module pcie_rs_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [TW-1:0] val_i,
  output logic          done_o
);
  logic [TW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load_i || (cnt_q != '0);
    cnt_d  = load_i ? val_i : cnt_q - TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/pcie_rs_gates.sv
module pcie_rs_gates #(
  parameter int NCLK = 3,
  parameter int IW   = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set_i,
  input  logic            clr_i,
  input  logic [IW-1:0]   idx_i,
  output logic [NCLK-1:0] en_o
);
  logic [NCLK-1:0] en_q, en_d;
  logic            upd;

  always_comb begin
    upd = set_i || clr_i;
    for (int i = 0; i < NCLK; i++) begin
      if (idx_i == IW'(i)) en_d[i] = set_i;
      else                 en_d[i] = en_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else if (upd) en_q <= en_d;
  end

  assign en_o = en_q;
endmodule

// File: rtl/pcie_rs_ctrl.sv
module pcie_rs_ctrl
  import pcie_rs_pkg::*;
#(
  parameter int NCLK        = 3,
  parameter int LSW         = 6,
  parameter int IW          = 2,
  parameter int TW          = 8,
  parameter int PD_WAIT     = 4,
  parameter int SETTLE_WAIT = 8,
  parameter int EPRST_WAIT  = 12,
  parameter int ACK_WAIT    = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic            shutdown_i,
  input  logic            refclk_on_i,
  input  logic            ltssm_on_i,
  input  logic [LSW-1:0]  link_state_i,
  input  logic [NCLK-1:0] clk_ack_i,
  input  logic            tmr_done_i,
  output logic            tmr_load_o,
  output logic [TW-1:0]   tmr_val_o,
  output logic            gate_set_o,
  output logic            gate_clr_o,
  output logic [IW-1:0]   gate_idx_o,
  output logic            ltssm_en_o,
  output logic            phy_pd_o,
  output logic            refclk_en_o,
  output logic            force_link_o,
  output logic [LSW-1:0]  link_state_o,
  output logic            ep_rst_n_o,
  output logic            done_o,
  output logic            err_o
);
  localparam logic [IW-1:0] LAST = IW'(NCLK - 1);

  seq_state_e     st_q, st_d;
  logic [IW-1:0]  idx_q, idx_d;
  logic [LSW-1:0] ls_q, ls_d;
  logic ltssm_q, ltssm_d, pd_q, pd_d, ref_q, ref_d, fl_q, fl_d;
  logic ep_q, ep_d, err_q, err_d, own_q, own_d, shut_q, shut_d;

  always_comb begin
    st_d = st_q;   idx_d = idx_q;   ls_d = ls_q;    ltssm_d = ltssm_q;
    pd_d = pd_q;   ref_d = ref_q;   fl_d = fl_q;    ep_d = ep_q;
    err_d = err_q; own_d = own_q;   shut_d = shut_q;
    tmr_load_o = 1'b0; tmr_val_o = '0;
    gate_set_o = 1'b0; gate_clr_o = 1'b0; gate_idx_o = idx_q;
    case (st_q)
      S_IDLE: begin
        if (!own_q) begin
          ltssm_d = ltssm_on_i; ref_d = refclk_on_i; ls_d = link_state_i;
        end
        if (start_i || shutdown_i) begin
          own_d = 1'b1; err_d = 1'b0; shut_d = !start_i;
          if (refclk_on_i && ltssm_on_i) begin
            st_d = S_FORCE; fl_d = 1'b1; ls_d = '0;
          end else begin
            st_d = S_PDON; fl_d = 1'b0; pd_d = 1'b1;
          end
        end
      end
      S_FORCE: begin st_d = S_LTOFF; ltssm_d = 1'b0; end
      S_LTOFF: begin st_d = S_PDON;  pd_d = 1'b1; end
      S_PDON:  begin st_d = S_REFOFF; ref_d = 1'b0; end
      S_REFOFF: begin
        if (shut_q) st_d = S_FIN;
        else begin
          st_d = S_CLKEN; idx_d = '0;
          gate_set_o = 1'b1; gate_idx_o = '0;
          tmr_load_o = 1'b1; tmr_val_o = TW'(ACK_WAIT);
        end
      end
      S_CLKEN: begin
        if (clk_ack_i[idx_q]) begin
          if (idx_q == LAST) begin
            st_d = S_PWRUP; pd_d = 1'b0;
            tmr_load_o = 1'b1; tmr_val_o = TW'(PD_WAIT);
          end else begin
            idx_d = idx_q + IW'(1);
            gate_set_o = 1'b1; gate_idx_o = idx_q + IW'(1);
            tmr_load_o = 1'b1; tmr_val_o = TW'(ACK_WAIT);
          end
        end else if (tmr_done_i) begin
          st_d = S_UNWIND; gate_clr_o = 1'b1;
        end
      end
      S_UNWIND: begin
        if (idx_q == '0) begin
          st_d = S_FIN; err_d = 1'b1;
        end else begin
          idx_d = idx_q - IW'(1);
          gate_clr_o = 1'b1; gate_idx_o = idx_q - IW'(1);
        end
      end
      S_PWRUP: if (tmr_done_i) begin
        st_d = S_REFON; ref_d = 1'b1;
        tmr_load_o = 1'b1; tmr_val_o = TW'(SETTLE_WAIT);
      end
      S_REFON: if (tmr_done_i) begin
        st_d = S_EPRST; ep_d = 1'b0;
        tmr_load_o = 1'b1; tmr_val_o = TW'(EPRST_WAIT);
      end
      S_EPRST: if (tmr_done_i) begin st_d = S_FIN; ep_d = 1'b1; end
      S_FIN:   st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE; idx_q <= '0; ls_q <= '0; ltssm_q <= 1'b0;
      pd_q <= 1'b0; ref_q <= 1'b0; fl_q <= 1'b0; ep_q <= 1'b0;
      err_q <= 1'b0; own_q <= 1'b0; shut_q <= 1'b0;
    end else begin
      st_q <= st_d; idx_q <= idx_d; ls_q <= ls_d; ltssm_q <= ltssm_d;
      pd_q <= pd_d; ref_q <= ref_d; fl_q <= fl_d; ep_q <= ep_d;
      err_q <= err_d; own_q <= own_d; shut_q <= shut_d;
    end
  end

  assign ltssm_en_o   = ltssm_q;
  assign phy_pd_o     = pd_q;
  assign refclk_en_o  = ref_q;
  assign force_link_o = fl_q;
  assign link_state_o = ls_q;
  assign ep_rst_n_o   = ep_q;
  assign done_o       = (st_q == S_FIN);
  assign err_o        = err_q;
endmodule

// File: rtl/pcie_rst_seq.sv
module pcie_rst_seq #(
  parameter int NCLK        = 3,
  parameter int LSW         = 6,
  parameter int PD_WAIT     = 1000,
  parameter int SETTLE_WAIT = 20000,
  parameter int EPRST_WAIT  = 10000000,
  parameter int ACK_WAIT    = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic            shutdown_i,
  input  logic            refclk_on_i,
  input  logic            ltssm_on_i,
  input  logic [LSW-1:0]  link_state_i,
  input  logic [NCLK-1:0] clk_ack_i,
  output logic            ltssm_en_o,
  output logic            phy_pd_o,
  output logic            refclk_en_o,
  output logic            force_link_o,
  output logic [LSW-1:0]  link_state_o,
  output logic [NCLK-1:0] clk_en_o,
  output logic            ep_rst_n_o,
  output logic            done_o,
  output logic            err_o
);
  localparam int IW   = (NCLK > 1) ? $clog2(NCLK) : 1;
  localparam int M1   = (PD_WAIT > SETTLE_WAIT) ? PD_WAIT : SETTLE_WAIT;
  localparam int M2   = (EPRST_WAIT > ACK_WAIT) ? EPRST_WAIT : ACK_WAIT;
  localparam int MAXW = (M1 > M2) ? M1 : M2;
  localparam int TW   = $clog2(MAXW + 1);

  logic [1:0]    rsync_q;
  logic          rst_core_n;
  logic          tmr_load, tmr_done, g_set, g_clr;
  logic [TW-1:0] tmr_val;
  logic [IW-1:0] g_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_core_n = rsync_q[1];

  pcie_rs_ctrl #(
    .NCLK(NCLK), .LSW(LSW), .IW(IW), .TW(TW), .PD_WAIT(PD_WAIT),
    .SETTLE_WAIT(SETTLE_WAIT), .EPRST_WAIT(EPRST_WAIT), .ACK_WAIT(ACK_WAIT)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_core_n), .start_i(start_i), .shutdown_i(shutdown_i),
    .refclk_on_i(refclk_on_i), .ltssm_on_i(ltssm_on_i), .link_state_i(link_state_i),
    .clk_ack_i(clk_ack_i), .tmr_done_i(tmr_done), .tmr_load_o(tmr_load),
    .tmr_val_o(tmr_val), .gate_set_o(g_set), .gate_clr_o(g_clr), .gate_idx_o(g_idx),
    .ltssm_en_o(ltssm_en_o), .phy_pd_o(phy_pd_o), .refclk_en_o(refclk_en_o),
    .force_link_o(force_link_o), .link_state_o(link_state_o),
    .ep_rst_n_o(ep_rst_n_o), .done_o(done_o), .err_o(err_o)
  );

  pcie_rs_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_core_n), .load_i(tmr_load), .val_i(tmr_val), .done_o(tmr_done)
  );

  pcie_rs_gates #(.NCLK(NCLK), .IW(IW)) u_gates (
    .clk(clk), .rst_n(rst_core_n), .set_i(g_set), .clr_i(g_clr), .idx_i(g_idx),
    .en_o(clk_en_o)
  );
endmodule

// File: rtl/pcie_rst_seq_chk.sv
module pcie_rst_seq_chk #(
  parameter int NCLK       = 3,
  parameter int LSW        = 6,
  parameter int EPRST_WAIT = 12
) (
  input logic            clk,
  input logic            rst_n,
  input logic            phy_pd_o,
  input logic            refclk_en_o,
  input logic            force_link_o,
  input logic [LSW-1:0]  link_state_o,
  input logic [NCLK-1:0] clk_en_o,
  input logic            ep_rst_n_o,
  input logic            done_o,
  input logic            err_o
);
  localparam int CW = $clog2(EPRST_WAIT + 2);
  localparam logic [CW-1:0] CMAX = CW'(EPRST_WAIT + 1);

  logic [CW-1:0] low_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 low_cnt <= '0;
    else if (ep_rst_n_o)        low_cnt <= '0;
    else if (low_cnt != CMAX)   low_cnt <= low_cnt + CW'(1);
  end

  a_r5_refclk_after_powerup: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(refclk_en_o) |-> !phy_pd_o);

  a_r2_force_detect: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(force_link_o) |-> (link_state_o == '0));

  for (genvar i = 1; i < NCLK; i++) begin : g_ord
    a_r4_gate_order: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(clk_en_o[i]) |-> clk_en_o[i-1]);
  end

  a_r6_release_ready: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ep_rst_n_o) |-> (refclk_en_o && !phy_pd_o && (&clk_en_o)));

  a_r6_low_window: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ep_rst_n_o) |-> (low_cnt >= CW'(EPRST_WAIT)));

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r8_fail_closed: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_o) |-> (done_o && (clk_en_o == '0)));
endmodule

bind pcie_rst_seq pcie_rst_seq_chk #(.NCLK(NCLK), .LSW(LSW), .EPRST_WAIT(EPRST_WAIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .phy_pd_o(phy_pd_o), .refclk_en_o(refclk_en_o),
  .force_link_o(force_link_o), .link_state_o(link_state_o), .clk_en_o(clk_en_o),
  .ep_rst_n_o(ep_rst_n_o), .done_o(done_o), .err_o(err_o)
);

// File: tb/pcie_rst_seq_tb_top.sv
module pcie_rst_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int P_PD = 4, P_SET = 8, P_EP = 12, P_ACK = 6;

  logic clk = 1'b0, rst_n = 1'b0, start_i = 1'b0, shutdown_i = 1'b0;
  logic refclk_on_i = 1'b0, ltssm_on_i = 1'b0;
  logic [5:0] link_state_i = '0;
  logic [2:0] ack_q = '0, ack_mask = 3'b111;
  logic ltssm_en_o, phy_pd_o, refclk_en_o, force_link_o, ep_rst_n_o, done_o, err_o;
  logic [5:0] link_state_o;
  logic [2:0] clk_en_o;

  int checks = 0, errors = 0, cyc = 0, done_cnt = 0;
  int t_fl_rise, t_lt_fall, t_pd_rise, t_pd_fall, t_ref_rise, t_ref_fall, t_ep_fall, t_ep_rise;
  int t_cr[3], t_cf[3];
  logic [5:0] ls_at_fl;
  logic p_fl, p_lt, p_pd, p_ref, p_ep;
  logic [2:0] p_ce;

  pcie_rst_seq #(.PD_WAIT(P_PD), .SETTLE_WAIT(P_SET), .EPRST_WAIT(P_EP), .ACK_WAIT(P_ACK)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .shutdown_i(shutdown_i),
    .refclk_on_i(refclk_on_i), .ltssm_on_i(ltssm_on_i), .link_state_i(link_state_i),
    .clk_ack_i(ack_q), .ltssm_en_o(ltssm_en_o), .phy_pd_o(phy_pd_o),
    .refclk_en_o(refclk_en_o), .force_link_o(force_link_o), .link_state_o(link_state_o),
    .clk_en_o(clk_en_o), .ep_rst_n_o(ep_rst_n_o), .done_o(done_o), .err_o(err_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) ack_q <= clk_en_o & ack_mask;

  always @(negedge clk) begin
    cyc++;
    if (force_link_o && !p_fl) begin t_fl_rise = cyc; ls_at_fl = link_state_o; end
    if (!ltssm_en_o && p_lt) t_lt_fall = cyc;
    if (phy_pd_o && !p_pd) t_pd_rise = cyc;
    if (!phy_pd_o && p_pd) t_pd_fall = cyc;
    if (refclk_en_o && !p_ref) t_ref_rise = cyc;
    if (!refclk_en_o && p_ref) t_ref_fall = cyc;
    if (!ep_rst_n_o && p_ep) t_ep_fall = cyc;
    if (ep_rst_n_o && !p_ep) t_ep_rise = cyc;
    for (int i = 0; i < 3; i++) begin
      if (clk_en_o[i] && !p_ce[i]) t_cr[i] = cyc;
      if (!clk_en_o[i] && p_ce[i]) t_cf[i] = cyc;
    end
    if (done_o) done_cnt++;
    p_fl = force_link_o; p_lt = ltssm_en_o; p_pd = phy_pd_o;
    p_ref = refclk_en_o; p_ep = ep_rst_n_o; p_ce = clk_en_o;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_log();
    @(posedge clk);
    t_fl_rise = -1; t_lt_fall = -1; t_pd_rise = -1; t_pd_fall = -1;
    t_ref_rise = -1; t_ref_fall = -1; t_ep_fall = -1; t_ep_rise = -1;
    for (int i = 0; i < 3; i++) begin t_cr[i] = -1; t_cf[i] = -1; end
    done_cnt = 0; ls_at_fl = 6'h3f;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse(input logic s, input logic h);
    @(negedge clk);
    start_i = s; shutdown_i = h;
    @(negedge clk);
    start_i = 1'b0; shutdown_i = 1'b0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 400 && done_cnt == 0; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset_adopt();
    refclk_on_i = 1'b1; ltssm_on_i = 1'b1; link_state_i = 6'h2a;
    do_reset();
    chk(ltssm_en_o == 1'b1, "R1 ltssm adopt", ltssm_en_o, 1);
    chk(refclk_en_o == 1'b1, "R1 refclk adopt", refclk_en_o, 1);
    chk(link_state_o == 6'h2a, "R1 link state adopt", link_state_o, 6'h2a);
    chk({phy_pd_o, force_link_o, ep_rst_n_o, done_o, err_o} == 5'b0, "R1 idle outputs",
        {phy_pd_o, force_link_o, ep_rst_n_o, done_o, err_o}, 0);
    chk(clk_en_o == 3'b000, "R1 gates closed", clk_en_o, 0);
    link_state_i = 6'h15; refclk_on_i = 1'b0;
    repeat (2) @(negedge clk);
    chk(link_state_o == 6'h15 && refclk_en_o == 1'b0, "R1 follow inputs", link_state_o, 6'h15);
    refclk_on_i = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_warm_bringup();
    clear_log();
    pulse(1'b1, 1'b0);
    wait_done();
    chk(t_fl_rise >= 0 && ls_at_fl == 6'h00, "R2 forced to detect", ls_at_fl, 0);
    chk(t_fl_rise < t_lt_fall, "R2 force before ltssm off", t_fl_rise, t_lt_fall - 1);
    chk(t_lt_fall < t_pd_rise, "R3 ltssm off before power-down", t_lt_fall, t_pd_rise - 1);
    chk(t_pd_rise < t_ref_fall, "R3 power-down before refclk off", t_pd_rise, t_ref_fall - 1);
    chk(t_cr[0] > t_ref_fall && t_cr[0] < t_cr[1] && t_cr[1] < t_cr[2], "R4 gate order", t_cr[1], t_cr[0] + 1);
    chk(t_pd_fall > t_cr[2], "R5 power-up after gates", t_pd_fall, t_cr[2] + 1);
    chk(t_ref_rise - t_pd_fall >= P_PD, "R5 power-up delay", t_ref_rise - t_pd_fall, P_PD);
    chk(t_ep_rise - t_ref_rise >= P_SET + P_EP, "R6 settle plus reset", t_ep_rise - t_ref_rise, P_SET + P_EP);
    chk(done_cnt == 1 && err_o == 1'b0, "R9 single done no error", done_cnt, 1);
    chk({refclk_en_o, phy_pd_o, clk_en_o, ep_rst_n_o} == 6'b101111, "R6 final state",
        {refclk_en_o, phy_pd_o, clk_en_o, ep_rst_n_o}, 6'b101111);
  endtask

  task automatic t_restart_busy();
    refclk_on_i = 1'b0; ltssm_on_i = 1'b0;
    clear_log();
    pulse(1'b1, 1'b0);
    repeat (5) @(negedge clk);
    pulse(1'b1, 1'b1);
    wait_done();
    repeat (40) @(negedge clk);
    chk(force_link_o == 1'b0 && t_fl_rise == -1, "R2 no force when link down", force_link_o, 0);
    chk(t_ep_fall - t_ref_rise >= P_SET, "R6 settle before endpoint reset", t_ep_fall - t_ref_rise, P_SET);
    chk(t_ep_rise - t_ep_fall >= P_EP, "R6 endpoint reset width", t_ep_rise - t_ep_fall, P_EP);
    chk(done_cnt == 1, "R10 busy commands ignored", done_cnt, 1);
    chk(refclk_en_o == 1'b1 && ep_rst_n_o == 1'b1, "R10 no shutdown taken", refclk_en_o, 1);
  endtask

  task automatic t_shutdown();
    refclk_on_i = 1'b1; ltssm_on_i = 1'b1;
    clear_log();
    pulse(1'b0, 1'b1);
    wait_done();
    chk(phy_pd_o == 1'b1 && refclk_en_o == 1'b0, "R7 link left down", {phy_pd_o, refclk_en_o}, 2'b10);
    chk(clk_en_o == 3'b111, "R7 gates untouched", clk_en_o, 3'b111);
    chk(ep_rst_n_o == 1'b1 && t_ep_fall == -1, "R7 endpoint reset untouched", ep_rst_n_o, 1);
    chk(force_link_o == 1'b1 && link_state_o == 6'h00, "R2 force on shutdown", link_state_o, 0);
    chk(t_pd_fall == -1 && done_cnt == 1, "R7 no power-up half", t_pd_fall, -1);
  endtask

  task automatic t_ack_fail();
    refclk_on_i = 1'b0; ltssm_on_i = 1'b0; ack_mask = 3'b011;
    do_reset();
    clear_log();
    pulse(1'b1, 1'b0);
    wait_done();
    chk(err_o == 1'b1 && done_cnt == 1, "R8 error flagged", err_o, 1);
    chk(clk_en_o == 3'b000, "R8 gates closed", clk_en_o, 0);
    chk(t_cf[1] - t_cf[2] == 1 && t_cf[0] - t_cf[1] == 1, "R8 descending close", t_cf[0] - t_cf[2], 2);
    chk(t_cf[2] - t_cr[2] >= P_ACK, "R8 ack wait", t_cf[2] - t_cr[2], P_ACK);
    chk(t_ref_rise == -1 && ep_rst_n_o == 1'b0 && phy_pd_o == 1'b1, "R8 stays down", t_ref_rise, -1);
  endtask

  task automatic t_recover();
    ack_mask = 3'b111;
    clear_log();
    pulse(1'b1, 1'b0);
    repeat (2) @(negedge clk);
    chk(err_o == 1'b0, "R9 error cleared on command", err_o, 0);
    wait_done();
    chk(t_cr[0] < t_cr[1] && t_cr[1] < t_cr[2], "R4 gate order after failure", t_cr[2], t_cr[1] + 1);
    chk(t_ref_rise - t_pd_fall >= P_PD, "R5 power-up delay again", t_ref_rise - t_pd_fall, P_PD);
    chk(ep_rst_n_o == 1'b1 && err_o == 1'b0 && done_cnt == 1, "R9 success after retry", ep_rst_n_o, 1);
  endtask

  task automatic t_both_cmds();
    clear_log();
    pulse(1'b1, 1'b1);
    wait_done();
    chk(t_ref_fall >= 0 && refclk_en_o == 1'b1, "R10 start wins", refclk_en_o, 1);
    chk(ep_rst_n_o == 1'b1 && done_cnt == 1, "R10 full bring-up ran", done_cnt, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset_adopt();
    t_warm_bringup();
    t_restart_busy();
    t_shutdown();
    t_ack_fail();
    t_recover();
    t_both_cmds();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule